// File: doc/BRIEF.md
# Programmable Power-Rail Sequencing Engine

This block runs a table-driven state machine that switches the enable lines of a board's power rails. It watches eight supply-good flags from external threshold detectors, four general-purpose logic inputs and one warning flag. All thirteen are asynchronous, and each passes through a two-flop synchronizer before the machine uses it. Each state of the table drives its own pattern on the eight enable outputs. Power-up orderings and power-down orderings are therefore both written as chains of states.

Every state has three exits, and each exit has its own target state. The sequence exit is taken when a chosen set of monitored signals all sit at chosen levels. An example is leaving idle once supply 0 is good and logic input 0 is low. The timeout exit is taken after a programmed number of 100 µs ticks spent in the state. The fault exit is taken when any watched signal reaches its fault level, for example a rail that has already been sequenced dropping out of its good window.

A host loads the table through a plain write strobe. Each write sets one field of one state, and a write is accepted in every cycle. The host can also force the machine into any state. A table with nothing loaded parks in state 0 with every enable low.

Top module: `rail_sequencer`

## Requirements
- R1: After reset, cur_state is 0 and en_out is all zero. With an unprogrammed table the machine stays in state 0 whatever the inputs do.
- R2: en_out always equals the output pattern stored for the current state.
- R3: The monitored vector is {warn, din[3:0], supply_ok[7:0]}: bits 7:0 are supplies, bits 11:8 are logic inputs and bit 12 is the warning. The sequence exit to the sequence target is taken when every bit set in the sequence mask equals the matching bit of the sequence level. A mask of zero disables this exit.
- R4: The fault exit to the fault target is taken when any bit set in the fault mask equals the matching bit of the fault level. The bits are ORed, and a mask of zero disables this exit.
- R5: With a timeout value T other than 0, the timeout exit to the timeout target happens exactly T*TICK_DIV clock cycles after entry. A value of 0 disables this exit.
- R6: When several exits are true in one cycle, the fault exit is taken before the timeout exit, and the timeout exit before the sequence exit.
- R7: force_req moves the machine to force_state at the next clock edge. It overrides every exit.
- R8: A change on a monitored input is first used by the machine two clock edges after it is driven. A resulting exit shows on cur_state at the third edge.
- R9: Every state entry restarts the tick prescaler and the timeout count. This includes a forced re-entry of the current state.
- R10: A write with cfg_we high stores cfg_data into one field of state cfg_state. The field is chosen by cfg_field: 0 is the output pattern, 1 is the sequence mask, 2 is the sequence level, 3 is the fault mask, 4 is the fault level and 5 is the timeout. Code 6 holds the targets: bits 3:0 are the sequence target, bits 7:4 the timeout target and bits 11:8 the fault target. Code 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| supply_ok | input | 8 | Supply-good flags from threshold detectors, asynchronous |
| din | input | 4 | General-purpose logic inputs, asynchronous |
| warn | input | 1 | Warning flag from readback limits or secondary monitors, asynchronous |
| cfg_we | input | 1 | Table write strobe |
| cfg_state | input | 4 | State whose field is written |
| cfg_field | input | 3 | Field code of the write |
| cfg_data | input | 13 | Write data, right-aligned |
| force_req | input | 1 | Request a forced state change |
| force_state | input | 4 | Target of a forced change |
| en_out | output | 8 | Rail enable pattern of the current state |
| cur_state | output | 4 | Current state number |

## Verification
The embedded properties assume that force_state and every programmed target name a state that exists. They also assume that a table write aimed at the current state does not arrive in the same cycle as an exit. The monitored inputs are taken to be levels that stay steady for at least the two synchronizer stages. The stimulus changes inputs only at falling edges and holds them for several cycles. It rewrites a state's fields only while the machine is parked in a different state that has no armed exits. It moves the machine with forced entries, so every timing window starts from a known entry edge.

// File: rtl/rseq_pkg.sv
package rseq_pkg;

  typedef enum logic [2:0] {
    FLD_OUT      = 3'd0,
    FLD_SEQ_MASK = 3'd1,
    FLD_SEQ_LVL  = 3'd2,
    FLD_FLT_MASK = 3'd3,
    FLD_FLT_LVL  = 3'd4,
    FLD_TMO      = 3'd5,
    FLD_NEXT     = 3'd6
  } cfg_field_e;

  typedef enum logic [2:0] {
    EX_NONE,
    EX_SEQ,
    EX_TMO,
    EX_FLT,
    EX_FORCE
  } exit_cause_e;

endpackage

// File: rtl/rseq_sync.sv
module rseq_sync #(
  parameter int W = 13
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage1 <= '0;
      d_sync <= '0;
    end else begin
      stage1 <= d_async;
      d_sync <= stage1;
    end
  end
endmodule

// File: rtl/rseq_tick.sv
module rseq_tick #(
  parameter int DIV = 5000
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  generate
    if (DIV <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_div
      localparam int PW = $clog2(DIV);
      localparam logic [PW-1:0] LAST = PW'(DIV - 1);
      logic [PW-1:0] pre;

      always_ff @(posedge clk) begin
        if (rst || restart)   pre <= '0;
        else if (pre == LAST) pre <= '0;
        else                  pre <= pre + 1'b1;
      end

      assign tick = (pre == LAST);

      AST_TICK_SPACING: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R5
    end
  endgenerate
endmodule

// File: rtl/rseq_table.sv
module rseq_table
  import rseq_pkg::*;
#(
  parameter int NS    = 16,
  parameter int SW    = 4,
  parameter int NO    = 8,
  parameter int SIGW  = 13,
  parameter int TW    = 12,
  parameter int DW    = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [SW-1:0] wr_state,
  input  logic [2:0]    wr_field,
  input  logic [DW-1:0] wr_data,
  input  logic [SW-1:0] rd_state,
  output logic [NO-1:0] rd_out,
  output logic [SIGW-1:0] rd_seq_mask,
  output logic [SIGW-1:0] rd_seq_lvl,
  output logic [SIGW-1:0] rd_flt_mask,
  output logic [SIGW-1:0] rd_flt_lvl,
  output logic [TW-1:0] rd_tmo,
  output logic [SW-1:0] rd_seq_nx,
  output logic [SW-1:0] rd_tmo_nx,
  output logic [SW-1:0] rd_flt_nx
);
  logic [NO-1:0]   out_q      [NS];
  logic [SIGW-1:0] seq_mask_q [NS];
  logic [SIGW-1:0] seq_lvl_q  [NS];
  logic [SIGW-1:0] flt_mask_q [NS];
  logic [SIGW-1:0] flt_lvl_q  [NS];
  logic [TW-1:0]   tmo_q      [NS];
  logic [SW-1:0]   seq_nx_q   [NS];
  logic [SW-1:0]   tmo_nx_q   [NS];
  logic [SW-1:0]   flt_nx_q   [NS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int k = 0; k < NS; k++) begin
        out_q[k]      <= '0;
        seq_mask_q[k] <= '0;
        seq_lvl_q[k]  <= '0;
        flt_mask_q[k] <= '0;
        flt_lvl_q[k]  <= '0;
        tmo_q[k]      <= '0;
        seq_nx_q[k]   <= '0;
        tmo_nx_q[k]   <= '0;
        flt_nx_q[k]   <= '0;
      end
    end else if (wr_en && (int'(wr_state) < NS)) begin
      case (wr_field)
        FLD_OUT:      out_q[wr_state]      <= wr_data[NO-1:0];
        FLD_SEQ_MASK: seq_mask_q[wr_state] <= wr_data[SIGW-1:0];
        FLD_SEQ_LVL:  seq_lvl_q[wr_state]  <= wr_data[SIGW-1:0];
        FLD_FLT_MASK: flt_mask_q[wr_state] <= wr_data[SIGW-1:0];
        FLD_FLT_LVL:  flt_lvl_q[wr_state]  <= wr_data[SIGW-1:0];
        FLD_TMO:      tmo_q[wr_state]      <= wr_data[TW-1:0];
        FLD_NEXT: begin
          seq_nx_q[wr_state] <= wr_data[SW-1:0];
          tmo_nx_q[wr_state] <= wr_data[2*SW-1:SW];
          flt_nx_q[wr_state] <= wr_data[3*SW-1:2*SW];
        end
        default: ;
      endcase
    end
  end

  assign rd_out      = out_q[rd_state];
  assign rd_seq_mask = seq_mask_q[rd_state];
  assign rd_seq_lvl  = seq_lvl_q[rd_state];
  assign rd_flt_mask = flt_mask_q[rd_state];
  assign rd_flt_lvl  = flt_lvl_q[rd_state];
  assign rd_tmo      = tmo_q[rd_state];
  assign rd_seq_nx   = seq_nx_q[rd_state];
  assign rd_tmo_nx   = tmo_nx_q[rd_state];
  assign rd_flt_nx   = flt_nx_q[rd_state];
endmodule

// File: rtl/rail_sequencer.sv
module rail_sequencer
  import rseq_pkg::*;
#(
  parameter int N_SUPPLY = 8,
  parameter int N_DIN    = 4,
  parameter int N_OUT    = 8,
  parameter int N_STATES = 16,
  parameter int TICK_DIV = 5000,
  parameter int TMO_W    = 12,
  localparam int SW    = (N_STATES > 1) ? $clog2(N_STATES) : 1,
  localparam int SIGW  = N_SUPPLY + N_DIN + 1,
  localparam int WA    = (N_OUT > SIGW) ? N_OUT : SIGW,
  localparam int WB    = (TMO_W > 3 * SW) ? TMO_W : 3 * SW,
  localparam int CFG_W = (WA > WB) ? WA : WB
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [N_SUPPLY-1:0] supply_ok,
  input  logic [N_DIN-1:0]    din,
  input  logic                warn,
  input  logic                cfg_we,
  input  logic [SW-1:0]       cfg_state,
  input  logic [2:0]          cfg_field,
  input  logic [CFG_W-1:0]    cfg_data,
  input  logic                force_req,
  input  logic [SW-1:0]       force_state,
  output logic [N_OUT-1:0]    en_out,
  output logic [SW-1:0]       cur_state
);
  logic [SIGW-1:0]  sig;
  logic [N_OUT-1:0] tb_out;
  logic [SIGW-1:0]  seq_mask, seq_lvl, flt_mask, flt_lvl;
  logic [TMO_W-1:0] tmo_val, tmo_cnt;
  logic [SW-1:0]    seq_nx, tmo_nx, flt_nx;
  logic             tick, seq_ok, flt_hit, tmo_hit, take;
  logic [SW-1:0]    nxt_state;
  exit_cause_e      cause;

  rseq_sync #(.W(SIGW)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .d_async ({warn, din, supply_ok}),
    .d_sync  (sig)
  );

  rseq_table #(
    .NS(N_STATES), .SW(SW), .NO(N_OUT), .SIGW(SIGW), .TW(TMO_W), .DW(CFG_W)
  ) u_table (
    .clk         (clk),
    .rst         (rst),
    .wr_en       (cfg_we),
    .wr_state    (cfg_state),
    .wr_field    (cfg_field),
    .wr_data     (cfg_data),
    .rd_state    (cur_state),
    .rd_out      (tb_out),
    .rd_seq_mask (seq_mask),
    .rd_seq_lvl  (seq_lvl),
    .rd_flt_mask (flt_mask),
    .rd_flt_lvl  (flt_lvl),
    .rd_tmo      (tmo_val),
    .rd_seq_nx   (seq_nx),
    .rd_tmo_nx   (tmo_nx),
    .rd_flt_nx   (flt_nx)
  );

  rseq_tick #(.DIV(TICK_DIV)) u_tick (
    .clk     (clk),
    .rst     (rst),
    .restart (take),
    .tick    (tick)
  );

  // Exit conditions, each from the current state's table entry
  assign seq_ok  = (|seq_mask) && (((sig ~^ seq_lvl) & seq_mask) == seq_mask);
  assign flt_hit = |((sig ~^ flt_lvl) & flt_mask);
  assign tmo_hit = (tmo_val != '0) && tick && (tmo_cnt == tmo_val - 1'b1);

  always_comb begin
    if (force_req)    cause = EX_FORCE;
    else if (flt_hit) cause = EX_FLT;
    else if (tmo_hit) cause = EX_TMO;
    else if (seq_ok)  cause = EX_SEQ;
    else              cause = EX_NONE;
  end

  always_comb begin
    case (cause)
      EX_FORCE: nxt_state = force_state;
      EX_FLT:   nxt_state = flt_nx;
      EX_TMO:   nxt_state = tmo_nx;
      EX_SEQ:   nxt_state = seq_nx;
      default:  nxt_state = cur_state;
    endcase
  end

  assign take = (cause != EX_NONE);

  always_ff @(posedge clk) begin
    if (rst)       cur_state <= '0;
    else if (take) cur_state <= nxt_state;
  end

  always_ff @(posedge clk) begin
    if (rst || take) tmo_cnt <= '0;
    else if (tick)   tmo_cnt <= tmo_cnt + 1'b1;
  end

  assign en_out = tb_out;

  AST_FORCE_WINS: assert property (@(posedge clk) disable iff (rst)
    force_req |=> cur_state == $past(force_state)); // R7
  AST_FAULT_FIRST: assert property (@(posedge clk) disable iff (rst)
    (!force_req && flt_hit) |=> cur_state == $past(flt_nx)); // R6
  AST_TMO_BEATS_SEQ: assert property (@(posedge clk) disable iff (rst)
    (!force_req && !flt_hit && tmo_hit) |=> cur_state == $past(tmo_nx)); // R6
  AST_HOLD_WITHOUT_EXIT: assert property (@(posedge clk) disable iff (rst)
    (!force_req && !flt_hit && !tmo_hit && !seq_ok) |=> $stable(cur_state)); // R3
  AST_PATTERN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (cfg_we && cfg_field == 3'd0 && cfg_state == cur_state && !take)
      |=> en_out == $past(cfg_data[N_OUT-1:0])); // R10

  generate
    if (TICK_DIV > 1) begin : g_chk_restart
      AST_NO_EARLY_TIMEOUT: assert property (@(posedge clk) disable iff (rst)
        take |=> !tmo_hit); // R9
    end
  endgenerate
endmodule

// File: tb/rail_sequencer_test.sv
module rail_sequencer_test;
  localparam int DIV = 3;

  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  supply_ok;
  logic [3:0]  din;
  logic        warn;
  logic        cfg_we;
  logic [3:0]  cfg_state;
  logic [2:0]  cfg_field;
  logic [12:0] cfg_data;
  logic        force_req;
  logic [3:0]  force_state;
  logic [7:0]  en_out;
  logic [3:0]  cur_state;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  rail_sequencer #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .supply_ok(supply_ok), .din(din), .warn(warn),
    .cfg_we(cfg_we), .cfg_state(cfg_state), .cfg_field(cfg_field),
    .cfg_data(cfg_data), .force_req(force_req), .force_state(force_state),
    .en_out(en_out), .cur_state(cur_state)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_sig(input int v);
    {warn, din, supply_ok} = v[12:0];
  endtask

  task automatic wr(input int s, input int f, input int d);
    cfg_we = 1'b1; cfg_state = s[3:0]; cfg_field = f[2:0]; cfg_data = d[12:0];
    step(1);
    cfg_we = 1'b0;
  endtask

  task automatic force_to(input int s);
    force_req = 1'b1; force_state = s[3:0];
    step(1);
    force_req = 1'b0;
  endtask

  initial begin
    rst = 1'b1; cfg_we = 0; cfg_state = 0; cfg_field = 0; cfg_data = 0;
    force_req = 0; force_state = 0; set_sig(0);
    step(3);
    rst = 1'b0;
    step(1);
    check("R1 reset state", int'(cur_state), 0);
    check("R1 reset enables", int'(en_out), 0);
    set_sig(13'h1FFF);
    step(6);
    check("R1 unprogrammed table stays idle", int'(cur_state), 0);
    set_sig(0);

    // R2 / R10: output patterns
    for (int s = 1; s < 16; s++) wr(s, 0, (s * 37 + 5) & 255);
    for (int s = 1; s < 16; s++) begin
      force_to(s);
      check("R2 pattern follows state", int'(en_out), (s * 37 + 5) & 255);
    end
    force_to(0);
    check("R2 state 0 pattern", int'(en_out), 0);

    // R3 sweep: single-bit sequence condition, both levels
    wr(1, 6, 2);
    for (int i = 0; i < 13; i++) begin
      for (int lvl = 0; lvl < 2; lvl++) begin
        int base;
        base = lvl ? 0 : 13'h1FFF;
        wr(1, 1, 1 << i);
        wr(1, 2, lvl ? (1 << i) : 0);
        set_sig(base);
        step(3);
        force_to(1);
        step(3);
        check("R3 holds while condition false", int'(cur_state), 1);
        set_sig(base ^ (1 << i));
        step(2);
        check("R8 not yet seen after two edges", int'(cur_state), 1);
        step(1);
        check("R3 advance on third edge", int'(cur_state), 2);
      end
    end
    // R3: two-term condition, supply0 good and din0 low
    wr(1, 1, 13'h101);
    wr(1, 2, 13'h001);
    set_sig(13'h101);
    step(3);
    force_to(1);
    step(4);
    check("R3 AND: din0 high blocks", int'(cur_state), 1);
    set_sig(0);
    step(4);
    check("R3 AND: supply0 low blocks", int'(cur_state), 1);
    set_sig(13'h001);
    step(3);
    check("R3 AND: both met advances", int'(cur_state), 2);
    wr(1, 1, 0);
    wr(1, 2, 0);
    set_sig(0);
    step(3);
    force_to(1);
    step(8);
    check("R3 zero mask never advances", int'(cur_state), 1);

    // R4 sweep: two watched bits, only one moves
    wr(3, 6, 4 << 8);
    for (int i = 0; i < 13; i++) begin
      for (int lvl = 0; lvl < 2; lvl++) begin
        int base, mask;
        mask = (1 << i) | (1 << ((i + 5) % 13));
        base = lvl ? 0 : 13'h1FFF;
        wr(3, 3, mask);
        wr(3, 4, lvl ? mask : 0);
        set_sig(base);
        step(3);
        force_to(3);
        step(3);
        check("R4 no fault at safe level", int'(cur_state), 3);
        set_sig(base ^ (1 << i));
        step(3);
        check("R4 fault exit taken", int'(cur_state), 4);
      end
    end
    wr(3, 3, 0);
    set_sig(13'h1FFF);
    step(3);
    force_to(3);
    step(6);
    check("R4 zero mask never faults", int'(cur_state), 3);
    set_sig(0);
    step(3);

    // R5 timeout sweep
    wr(5, 6, 6 << 4);
    for (int t = 1; t <= 6; t++) begin
      wr(5, 5, t);
      force_to(5);
      step(t * DIV - 1);
      check("R5 before timeout", int'(cur_state), 5);
      step(1);
      check("R5 timeout exit", int'(cur_state), 6);
    end
    wr(5, 5, 0);
    force_to(5);
    step(40);
    check("R5 zero timeout disabled", int'(cur_state), 5);

    // R9 restart on forced re-entry
    wr(5, 5, 4);
    force_to(5);
    step(6);
    force_to(5);
    step(4 * DIV - 1);
    check("R9 window restarted", int'(cur_state), 5);
    step(1);
    check("R9 exit after full window", int'(cur_state), 6);

    // R6 priority on state 7
    wr(7, 1, 1);
    wr(7, 2, 1);
    wr(7, 3, 2);
    wr(7, 4, 2);
    wr(7, 5, 1);
    wr(7, 6, 8 | (10 << 4) | (9 << 8));
    set_sig(3); step(3); force_to(7); step(1);
    check("R6 fault over sequence", int'(cur_state), 9);
    set_sig(1); step(3); force_to(7); step(1);
    check("R3 sequence alone", int'(cur_state), 8);
    set_sig(0); step(3); force_to(7); set_sig(1); step(2);
    check("R6 none before tick", int'(cur_state), 7);
    step(1);
    check("R6 timeout over sequence", int'(cur_state), 10);
    set_sig(0); step(3); force_to(7); set_sig(3); step(3);
    check("R6 fault over timeout and sequence", int'(cur_state), 9);
    set_sig(0); step(3); force_to(7); set_sig(2); step(3);
    check("R6 fault over timeout", int'(cur_state), 9);
    set_sig(0); step(3); force_to(7); step(2);
    check("R5 timeout alone pending", int'(cur_state), 7);
    step(1);
    check("R5 timeout alone", int'(cur_state), 10);

    // R7 force sweep and override
    for (int s = 0; s < 16; s++) begin
      force_to(s);
      check("R7 forced state", int'(cur_state), s);
    end
    set_sig(2); step(3); force_to(7);
    force_to(12);
    check("R7 force over fault", int'(cur_state), 12);
    check("R2 pattern after force", int'(en_out), (12 * 37 + 5) & 255);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule